// File: doc/BRIEF.md
# Multi-Match 16-Bit Timer Controller

This block is a 16-bit timer. A prescale counter divides the clock, and the timer count takes one step each time the prescaler wraps, but only while the run bit is set. The count can go up, go down, or go up and down between zero and a period value. A bank of match registers watches the count. Each match channel has three actions of its own: raise a sticky interrupt flag, restart the count, or halt the timer. The last channel is the period channel.

Software reaches every setting through a single-cycle write port and a combinational read port. The block drives one interrupt line. It also drives a PWM pair made from channel 0: a true output and its complement. In one configuration the complement is forced low.

Restarting the count depends on the counting mode. Counting up, and counting up and down, restart at zero. Counting down restarts at the period value when dead-band is on, and at zero when it is off. When dead-band is on in down mode, the period channel's restart action is ignored.

Top module: `match_timer16`

## Requirements
- R1: After reset every register reads 0, the count is 0 and irq is 0.
- R2: With prescale value P, the count steps once every P+1 clocks while the run bit is 1. The count holds while the run bit is 0.
- R3: Control register (address 0) layout: bit 0 run, bits 2:1 mode, bit 3 dead-band. Mode 00 counts up and wraps. Mode 01 counts down and wraps. Mode 10 counts up to the period value (the last match channel), then down to 0, then up again.
- R4: A match is taken on a count step when the count equals a match value. The step then uses the match instead of the normal advance. A match whose restart bit is set, in up or up/down mode, makes the count 0.
- R5: In down mode a restart loads the period value when dead-band is on, and loads 0 when dead-band is off.
- R6: In down mode with dead-band on, the period channel's restart bit has no effect. With dead-band off, that bit works as in R5.
- R7: A match whose stop bit is set clears the run bit and freezes the count. If a restart and a stop happen on the same step, the count takes the restart value and then holds, and the run bit stays cleared.
- R8: A match with its interrupt bit set sets that channel's flag (address 3). Writing 1 to a flag bit clears it. irq is the OR of the flags whose interrupt bit is set.
- R9: Match-control register (address 2) layout: channel k uses bit 3k for interrupt, bit 3k+1 for restart and bit 3k+2 for stop. Bits above the last channel read as 0.
- R10: pwm_out is 1 while count < match 0, and pwm_n is its complement. pwm_n is held at 0 when all three hold: up/down mode, dead-band on, and the period channel's restart bit set.
- R11: Address map: 1 holds the prescale value, 4+k holds match k, and 4+NUM_CH reads the count. A write to 4+NUM_CH loads the count, clears the prescaler and sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Match interrupt |
| pwm_out | output | 1 | PWM output from channel 0 |
| pwm_n | output | 1 | Complementary PWM output |

## Verification
A wrong count direction or restart value appears in the count readback on the first step after the faulty match. In these tests that is within one to three clocks, because the prescale value is kept small. A stop that is lost shows up as the run bit still reading 1 and the count moving on past the stop value. A flag that is set wrongly, or cleared when it should stay, shows on irq in the clock right after the match step. The forced-low rule for pwm_n is pure decoding of the configuration, so it shows the moment the configuration is written.

// File: rtl/mt_pkg.sv
// Shared constants for the match timer: register addresses and mode codes.
package mt_pkg;
    localparam int A_CTRL   = 0;
    localparam int A_PRESC  = 1;
    localparam int A_MCTL   = 2;
    localparam int A_FLAGS  = 3;
    localparam int A_MATCH0 = 4;

    localparam logic [1:0] MODE_UP     = 2'b00;
    localparam logic [1:0] MODE_DOWN   = 2'b01;
    localparam logic [1:0] MODE_CENTER = 2'b10;
endpackage

// File: rtl/mt_prescale.sv
// Prescale divider. Counts 0..limit while run is high, and pulses tick on the
// wrap cycle. Assumes clear has priority and restarts the divider from 0.
module mt_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] pc_q;

    assign tick = run && (pc_q >= limit);

    // Advance the divider, wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pc_q <= '0;
        else if (tick)       pc_q <= '0;
        else if (run)        pc_q <= pc_q + 1'b1;
    end
endmodule

// File: rtl/mt_match_bank.sv
// Compares the count with every match value on a step and turns the hits into
// flag-set, restart and stop requests. Assumes the last channel is the period
// channel, whose restart is masked in down mode with dead-band on.
module mt_match_bank
    import mt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16
) (
    input  logic                         tick,
    input  logic [CNT_W-1:0]             count,
    input  logic [NUM_CH-1:0][CNT_W-1:0] match_val,
    input  logic [3*NUM_CH-1:0]          ctl,
    input  logic [1:0]                   mode,
    input  logic                         deadband,
    output logic [NUM_CH-1:0]            flag_set,
    output logic                         any_rst,
    output logic                         any_stop
);
    logic [NUM_CH-1:0] hit, rst_ok, stop_ok;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        // Per-channel compare and action qualification.
        assign hit[k]      = tick && (count == match_val[k]);
        assign flag_set[k] = hit[k] && ctl[3*k];
        assign stop_ok[k]  = ctl[3*k+2];
        if (k == NUM_CH - 1) begin : g_period
            assign rst_ok[k] = ctl[3*k+1] && !(deadband && mode == MODE_DOWN);
        end else begin : g_plain
            assign rst_ok[k] = ctl[3*k+1];
        end
    end

    assign any_rst  = |(hit & rst_ok);
    assign any_stop = |(hit & stop_ok);
endmodule

// File: rtl/mt_counter.sv
// Timer count register with up, down and up/down stepping. Assumes load wins
// over a step, and restart wins over stop for the value taken.
module mt_counter
    import mt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             deadband,
    input  logic             tick,
    input  logic             any_rst,
    input  logic             any_stop,
    input  logic [CNT_W-1:0] period,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    logic             up_q;
    logic [CNT_W-1:0] rst_val;

    // Restart value depends on mode and dead-band.
    assign rst_val = (mode == MODE_DOWN && deadband) ? period : '0;

    // Update count and up/down direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            up_q  <= 1'b1;
        end else if (load) begin
            count <= load_val;
            up_q  <= 1'b1;
        end else if (tick) begin
            if (any_rst) begin
                count <= rst_val;
                up_q  <= 1'b1;
            end else if (!any_stop) begin
                case (mode)
                    MODE_DOWN: count <= count - 1'b1;
                    MODE_CENTER: begin
                        if (up_q && count == period) begin
                            count <= count - 1'b1;
                            up_q  <= 1'b0;
                        end else if (!up_q && count == '0) begin
                            count <= count + 1'b1;
                            up_q  <= 1'b1;
                        end else if (up_q) begin
                            count <= count + 1'b1;
                        end else begin
                            count <= count - 1'b1;
                        end
                    end
                    default: count <= count + 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/match_timer16.sv
// Top of the match timer: register file, prescaler, match bank and counter,
// plus the PWM pair. Assumes software writes take effect at the next edge and
// a hardware stop wins over a same-cycle write of the run bit.
module match_timer16
    import mt_pkg::*;
#(
    parameter  int NUM_CH = 3,
    parameter  int CNT_W  = 16,
    parameter  int PRE_W  = 8,
    localparam int ADDR_W = $clog2(NUM_CH + 5)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              pwm_out,
    output logic              pwm_n
);
    localparam int CTL_W   = 3 * NUM_CH;
    localparam int A_COUNT = A_MATCH0 + NUM_CH;

    logic                         cen_q, db_q;
    logic [1:0]                   mode_q;
    logic [PRE_W-1:0]             presc_q;
    logic [CTL_W-1:0]             mctl_q;
    logic [NUM_CH-1:0]            flag_q, flag_set, ie_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] match_q;
    logic [CNT_W-1:0]             count;
    logic                         tick, any_rst, any_stop, cnt_wr, pwm_force;
    logic                         wr_ctrl, wr_presc, wr_mctl, wr_flags;
    logic                         unused_wbits;

    assign wr_ctrl  = wr_en && addr == ADDR_W'(A_CTRL);
    assign wr_presc = wr_en && addr == ADDR_W'(A_PRESC);
    assign wr_mctl  = wr_en && addr == ADDR_W'(A_MCTL);
    assign wr_flags = wr_en && addr == ADDR_W'(A_FLAGS);
    assign cnt_wr   = wr_en && addr == ADDR_W'(A_COUNT);
    assign unused_wbits = ^wdata;

    // Software-visible configuration and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_q   <= 1'b0;
            db_q    <= 1'b0;
            mode_q  <= MODE_UP;
            presc_q <= '0;
            mctl_q  <= '0;
            flag_q  <= '0;
            match_q <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= wdata[2:1];
                db_q   <= wdata[3];
            end
            if (tick && any_stop) cen_q <= 1'b0;
            else if (wr_ctrl)     cen_q <= wdata[0];
            if (wr_presc) presc_q <= wdata[PRE_W-1:0];
            if (wr_mctl)  mctl_q  <= wdata[CTL_W-1:0];
            flag_q <= (flag_q & ~(wr_flags ? wdata[NUM_CH-1:0] : '0)) | flag_set;
            for (int k = 0; k < NUM_CH; k++) begin
                if (wr_en && addr == ADDR_W'(A_MATCH0 + k)) match_q[k] <= wdata[CNT_W-1:0];
            end
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ie
        assign ie_vec[k] = mctl_q[3*k];
    end

    mt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cen_q), .clear(cnt_wr),
        .limit(presc_q), .tick(tick)
    );

    mt_match_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_bank (
        .tick(tick), .count(count), .match_val(match_q), .ctl(mctl_q),
        .mode(mode_q), .deadband(db_q), .flag_set(flag_set),
        .any_rst(any_rst), .any_stop(any_stop)
    );

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .deadband(db_q), .tick(tick),
        .any_rst(any_rst), .any_stop(any_stop), .period(match_q[NUM_CH-1]),
        .load(cnt_wr), .load_val(wdata[CNT_W-1:0]), .count(count)
    );

    // Outputs: interrupt and PWM pair with forced-low complement.
    assign irq       = |(flag_q & ie_vec);
    assign pwm_force = (mode_q == MODE_CENTER) && db_q && mctl_q[3*(NUM_CH-1)+1];
    assign pwm_out   = count < match_q[0];
    assign pwm_n     = !pwm_out && !pwm_force;

    // Combinational register read mux.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_CTRL))  rdata[3:0] = {db_q, mode_q, cen_q};
        if (addr == ADDR_W'(A_PRESC)) rdata[PRE_W-1:0] = presc_q;
        if (addr == ADDR_W'(A_MCTL))  rdata[CTL_W-1:0] = mctl_q;
        if (addr == ADDR_W'(A_FLAGS)) rdata[NUM_CH-1:0] = flag_q;
        for (int k = 0; k < NUM_CH; k++) begin
            if (addr == ADDR_W'(A_MATCH0 + k)) rdata[CNT_W-1:0] = match_q[k];
        end
        if (addr == ADDR_W'(A_COUNT)) rdata[CNT_W-1:0] = count;
    end
endmodule

// File: rtl/mt_checker.sv
// Property checker for match_timer16, attached by bind. Observes internal
// step, request and state signals; drives nothing.
module mt_checker #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              any_rst,
    input logic              any_stop,
    input logic              cen,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  count,
    input logic              cnt_wr,
    input logic              irq,
    input logic [NUM_CH-1:0] flags,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata
);
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = count + 1'b1;

    assert_stop_clears_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && any_stop) |=> !cen);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen && !cnt_wr) |=> $stable(count));

    assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'b00 && !any_rst && !any_stop && !cnt_wr) |=> count == $past(cnt_inc));

    assert_up_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'b00 && any_rst && !cnt_wr) |=> count == '0);

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(2)) |-> ((rdata >> (3*NUM_CH)) == 32'd0));
endmodule

bind match_timer16 mt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .any_rst(any_rst), .any_stop(any_stop),
    .cen(cen_q), .mode(mode_q), .count(count), .cnt_wr(cnt_wr), .irq(irq),
    .flags(flag_q), .addr(addr), .rdata(rdata)
);

// File: tb/match_timer16_test.sv
module match_timer16_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, pwm_out, pwm_n;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    match_timer16 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .pwm_out(pwm_out), .pwm_n(pwm_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a[2:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = a[2:0];
        #1;
        d = rdata;
    endtask

    // Disable, configure, clear flags, load count; caller then sets run.
    task automatic setup(input logic [31:0] ctl, input logic [31:0] pre, input logic [31:0] mctl,
                         input logic [15:0] m0, input logic [15:0] m1, input logic [15:0] m2,
                         input logic [15:0] cnt);
        wr(0, ctl & ~32'h1);
        wr(1, pre);
        wr(2, mctl);
        wr(4, {16'h0, m0});
        wr(5, {16'h0, m1});
        wr(6, {16'h0, m2});
        wr(3, 32'hFFFF_FFFF);
        wr(7, {16'h0, cnt});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk($sformatf("R1 reg %0d after reset", a), d, 32'h0);
        end
        chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_prescale();
        logic [31:0] d;
        setup(32'h0, 32'd2, 32'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'd0);
        wr(0, 32'h1);
        repeat (9) @(negedge clk);
        rd(7, d); chk("R2 prescale 2, 9 clocks", d, 32'd3);
        wr(0, 32'h0);
        repeat (5) @(negedge clk);
        rd(7, d); chk("R2 hold while stopped", d, 32'd3);
    endtask

    task automatic t_up_restart();
        logic [31:0] d;
        setup(32'h0, 32'd0, 32'h2, 16'd5, 16'hFFFF, 16'hFFFF, 16'd0);
        wr(0, 32'h1);
        repeat (8) @(negedge clk);
        rd(7, d); chk("R4 up restart at 5", d, 32'd2);
    endtask

    task automatic t_down();
        logic [31:0] d;
        setup(32'h2, 32'd0, 32'h2, 16'd7, 16'hFFFF, 16'd10, 16'd9);
        wr(0, 32'h3);
        repeat (4) @(negedge clk);
        rd(7, d); chk("R5 down restart no dead-band", d, 32'hFFFF);
        setup(32'hA, 32'd0, 32'h2, 16'd7, 16'hFFFF, 16'd10, 16'd9);
        wr(0, 32'hB);
        repeat (4) @(negedge clk);
        rd(7, d); chk("R5 down reload period with dead-band", d, 32'd9);
    endtask

    task automatic t_period_mask();
        logic [31:0] d;
        setup(32'hA, 32'd0, 32'h80, 16'hFFFF, 16'hFFFF, 16'd4, 16'd6);
        wr(0, 32'hB);
        repeat (3) @(negedge clk);
        rd(7, d); chk("R6 period restart ignored", d, 32'd3);
        setup(32'h2, 32'd0, 32'h80, 16'hFFFF, 16'hFFFF, 16'd4, 16'd6);
        wr(0, 32'h3);
        repeat (3) @(negedge clk);
        rd(7, d); chk("R6 period restart honoured without dead-band", d, 32'd0);
    endtask

    task automatic t_center();
        logic [31:0] d;
        setup(32'h4, 32'd0, 32'h0, 16'hFFFF, 16'hFFFF, 16'd3, 16'd0);
        wr(0, 32'h5);
        repeat (5) @(negedge clk);
        rd(7, d); chk("R3 center descending", d, 32'd1);
        repeat (3) @(negedge clk);
        rd(7, d); chk("R3 center turns at 0", d, 32'd2);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        setup(32'h0, 32'd0, 32'h20, 16'hFFFF, 16'd3, 16'hFFFF, 16'd0);
        wr(0, 32'h1);
        repeat (10) @(negedge clk);
        rd(7, d); chk("R7 stop freezes count", d, 32'd3);
        rd(0, d); chk("R7 stop clears run", d & 32'h1, 32'h0);
        setup(32'h0, 32'd0, 32'h22, 16'd3, 16'd3, 16'hFFFF, 16'd0);
        wr(0, 32'h1);
        repeat (10) @(negedge clk);
        rd(7, d); chk("R7 stop with restart holds 0", d, 32'd0);
        rd(0, d); chk("R7 stop with restart clears run", d & 32'h1, 32'h0);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        setup(32'h0, 32'd0, 32'h1, 16'd2, 16'd1, 16'hFFFF, 16'd0);
        wr(0, 32'h1);
        repeat (3) @(negedge clk);
        rd(3, d); chk("R8 flag set only with interrupt bit", d, 32'h1);
        chk("R8 irq high", {31'h0, irq}, 32'h1);
        wr(0, 32'h0);
        wr(2, 32'h0);
        #1;
        chk("R8 irq masked", {31'h0, irq}, 32'h0);
        rd(3, d); chk("R8 flag sticky while masked", d, 32'h1);
        wr(3, 32'h1);
        rd(3, d); chk("R8 write-one clears flag", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(0, 32'h0);
        wr(2, 32'hFFFF_FFFF);
        rd(2, d); chk("R9 reserved bits read 0", d, 32'h1FF);
        wr(2, 32'h0);
    endtask

    task automatic t_pwm();
        setup(32'hC, 32'd0, 32'h0, 16'd5, 16'hFFFF, 16'hFFFF, 16'd7);
        #1;
        chk("R10 pwm_out low above match", {31'h0, pwm_out}, 32'h0);
        chk("R10 pwm_n complement", {31'h0, pwm_n}, 32'h1);
        wr(2, 32'h80);
        #1;
        chk("R10 pwm_n forced low", {31'h0, pwm_n}, 32'h0);
        wr(0, 32'h4);
        #1;
        chk("R10 no force without dead-band", {31'h0, pwm_n}, 32'h1);
        wr(7, 32'd2);
        #1;
        chk("R10 R11 pwm_out high below match", {31'h0, pwm_out}, 32'h1);
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescale();
        t_up_restart();
        t_down();
        t_period_mask();
        t_center();
        t_stop();
        t_flags();
        t_reserved();
        t_pwm();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule